// File: doc/BRIEF.md
# Half-Duplex Ethernet Collision Supervisor

This block governs the transmit side of a half-duplex Ethernet MAC that runs a 4-bit, MII-style transceiver interface. A frame request starts an attempt. The block keeps transmit enable high for the requested number of nibbles and counts nibble positions from the first preamble nibble. It watches the transceiver's collision and carrier-sense lines.

A collision inside the collision window causes a jam and a random slot-based backoff, and then the frame is retransmitted. A collision at or past the window boundary aborts the frame with no retry. The boundary is programmable to 56 or 64 bytes. After a clean transmission the block can listen for the transceiver's heartbeat (SQE) pulse. A self-test mode forces a collision on every attempt. The receive-valid signal from the transceiver is passed on, and it can be blocked while the transmitter is busy.

Each finished frame is reported by a one-cycle completion strobe. The strobe comes with held status bits and a retry count. All configuration inputs are static mode bits and must only change while no frame is in progress.

Top module: `coll_supervisor`

## Requirements
- R1: With cfgLateSel low, a collision seen while sending nibble index 128 or later (index 0 is the first preamble nibble, 2 nibbles per byte) ends the frame at once: txEn drops on the next cycle and stLate is set. A collision at index 127 or earlier is treated as early.
- R2: With cfgLateSel high, the late boundary moves to nibble index 112: index 111 is early and index 112 is late.
- R3: An early collision raises txEn and jamEn together for exactly 8 cycles (32 bits). A backoff follows, and then the frame restarts from nibble index 0.
- R4: After the n-th collision of a frame, the backoff lasts s*SLOT_CLKS+1 cycles with txEn low. s is drawn from a free-running LFSR in the range 0 to 2^min(n,10)-1.
- R5: With cfgStopBackoff high, the backoff countdown holds, and the attempt does not restart, in every cycle in which phyCrs is high. With cfgStopBackoff low, phyCrs has no effect on the backoff length.
- R6: The 16th collision of a frame is still jammed, and then the frame is aborted with stRetryLimit set and stRetryCnt equal to 15.
- R7: With cfgForceColl high, every attempt collides at nibble index 0, so every frame ends with stRetryLimit.
- R8: With cfgHeartbeat high, after the last nibble the block waits up to 40 cycles for phyCol. A collision in any of those cycles completes the frame with stHbMissing low. If none arrives, the frame completes in the 40th cycle with stHbMissing high. With cfgHeartbeat low, completion follows the last nibble directly.
- R9: rxDvOut equals rxDvIn, except that it is forced low while txEn is high and cfgLocalProtect is low.
- R10: With cfgFullDuplex high, phyCol, cfgForceColl and cfgHeartbeat have no effect: the frame completes after its last nibble with all error bits clear.
- R11: doneStb is high for exactly one cycle per frame. stRetryCnt then holds the number of collisions the frame saw, and all status outputs hold until the next doneStb.
- R12: While rst_n is low, txEn, jamEn, doneStb and all status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgHeartbeat | input | 1 | Enable post-transmit heartbeat check |
| cfgForceColl | input | 1 | Self-test: collide on every attempt |
| cfgStopBackoff | input | 1 | Freeze backoff while carrier is present |
| cfgLocalProtect | input | 1 | 1 lets receive data through during transmit |
| cfgLateSel | input | 1 | 0: 64-byte late boundary, 1: 56-byte |
| cfgFullDuplex | input | 1 | Bypass collision and heartbeat handling |
| txReq | input | 1 | Request to send a frame, sampled when idle |
| frameNibbles | input | NIB_W | Frame length in nibbles including preamble, at least 1 |
| phyCol | input | 1 | Collision from transceiver |
| phyCrs | input | 1 | Carrier sense from transceiver |
| rxDvIn | input | 1 | Receive data valid from transceiver |
| txEn | output | 1 | Transmit enable (data or jam) |
| jamEn | output | 1 | Jam pattern being sent |
| rxDvOut | output | 1 | Gated receive data valid |
| doneStb | output | 1 | One-cycle frame completion strobe |
| stHbMissing | output | 1 | Heartbeat not heard |
| stLate | output | 1 | Late collision abort |
| stRetryLimit | output | 1 | Retry limit exceeded |
| stRetryCnt | output | RC_W | Collisions seen by the frame (15 on limit) |

## Verification
The bench places collisions on both sides of each late boundary, at nibble 127/128 and at 111/112. A design that counts from the wrong origin, or compares with > instead of >=, retries where it should abort, or the reverse. The heartbeat pulse is placed in the 40th cycle of the window and also left out. An off-by-one window would either miss the pulse or finish a cycle early. Carrier is held through a backoff with the freeze bit both set and clear. A design that ignores the bit, or that can leave a frozen backoff, restarts at the wrong time. Backoff lengths are checked against the slot quantum and the exponent cap. The sixteen-collision abort is driven both by the self-test bit and by real collisions, which catches a retry counter that stops one attempt early or late.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_JAM,
    ST_BACKOFF,
    ST_HBWAIT
  } csState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrNib;
    logic incNib;
    logic clrColl;
    logic incColl;
    logic loadJam;
    logic loadHb;
    logic loadBackoff;
    logic decTmr;
    logic finish;
    logic finLate;
    logic finLimit;
    logic finHbMiss;
  } csStrobe_t;

endpackage

// File: rtl/cs_datapath.sv
module cs_datapath
  import cs_pkg::*;
#(
  parameter int NIB_W        = 12,
  parameter int SLOT_CLKS    = 128,
  parameter int BO_CAP       = 10,
  parameter int MAX_ATTEMPTS = 16,
  parameter int JAM_CLKS     = 8,
  parameter int HB_CLKS      = 40,
  parameter int COLL_W       = 5,
  parameter int RC_W         = 4,
  parameter int TMR_W        = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  csStrobe_t         stb,
  output logic [NIB_W-1:0]  nibCnt,
  output logic [COLL_W-1:0] collCnt,
  output logic              tmrZero,
  output logic              doneStb,
  output logic              stHbMissing,
  output logic              stLate,
  output logic              stRetryLimit,
  output logic [RC_W-1:0]   stRetryCnt
);

  localparam int LFSR_W = 16;

  logic [TMR_W-1:0]  tmr;
  logic [LFSR_W-1:0] lfsr;
  logic [BO_CAP-1:0] slotMask;
  logic [BO_CAP-1:0] slots;
  logic [TMR_W-1:0]  boLoad;

  // mask bit i is set when more than i collisions have happened (cap at BO_CAP)
  always_comb begin
    for (int i = 0; i < BO_CAP; i++) begin
      slotMask[i] = (collCnt > COLL_W'(i));
    end
    slots  = (lfsr[BO_CAP-1:0] ^ lfsr[LFSR_W-1 -: BO_CAP]) & slotMask;
    boLoad = TMR_W'(slots) * TMR_W'(SLOT_CLKS);
  end

  assign tmrZero = (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 16'hACE1;
    end else begin
      lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nibCnt  <= '0;
      collCnt <= '0;
      tmr     <= '0;
    end else begin
      if (stb.clrNib)       nibCnt <= '0;
      else if (stb.incNib)  nibCnt <= nibCnt + 1'b1;

      if (stb.clrColl)      collCnt <= '0;
      else if (stb.incColl) collCnt <= collCnt + 1'b1;

      if (stb.loadJam)          tmr <= TMR_W'(JAM_CLKS - 1);
      else if (stb.loadHb)      tmr <= TMR_W'(HB_CLKS - 1);
      else if (stb.loadBackoff) tmr <= boLoad;
      else if (stb.decTmr)      tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneStb      <= 1'b0;
      stHbMissing  <= 1'b0;
      stLate       <= 1'b0;
      stRetryLimit <= 1'b0;
      stRetryCnt   <= '0;
    end else begin
      doneStb <= stb.finish;
      if (stb.finish) begin
        stHbMissing  <= stb.finHbMiss;
        stLate       <= stb.finLate;
        stRetryLimit <= stb.finLimit;
        stRetryCnt   <= stb.finLimit ? RC_W'(MAX_ATTEMPTS - 1) : collCnt[RC_W-1:0];
      end
    end
  end

endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_pkg::*;
#(
  parameter int NIB_W            = 12,
  parameter int MAX_ATTEMPTS     = 16,
  parameter int COLL_W           = 5,
  parameter int LATE_LONG_BYTES  = 64,
  parameter int LATE_SHORT_BYTES = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgHeartbeat,
  input  logic              cfgForceColl,
  input  logic              cfgStopBackoff,
  input  logic              cfgLateSel,
  input  logic              cfgFullDuplex,
  input  logic              txReq,
  input  logic [NIB_W-1:0]  frameNibbles,
  input  logic              phyCol,
  input  logic              phyCrs,
  input  logic [NIB_W-1:0]  nibCnt,
  input  logic [COLL_W-1:0] collCnt,
  input  logic              tmrZero,
  output csStrobe_t         stb,
  output logic              txEn,
  output logic              jamEn,
  output logic              inBackoff
);

  localparam logic [NIB_W-1:0] LATE_LONG_NIB  = NIB_W'(2 * LATE_LONG_BYTES);
  localparam logic [NIB_W-1:0] LATE_SHORT_NIB = NIB_W'(2 * LATE_SHORT_BYTES);

  csState_e state, stateNxt;
  logic     colHit, lateHit, lastNib, hbOn, frozen;

  assign colHit  = (phyCol | (cfgForceColl & (nibCnt == '0))) & ~cfgFullDuplex;
  assign lateHit = nibCnt >= (cfgLateSel ? LATE_SHORT_NIB : LATE_LONG_NIB);
  assign lastNib = (nibCnt == frameNibbles - 1'b1);
  assign hbOn    = cfgHeartbeat & ~cfgFullDuplex;
  assign frozen  = cfgStopBackoff & phyCrs;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (txReq) begin
        stateNxt    = ST_TX;
        stb.clrNib  = 1'b1;
        stb.clrColl = 1'b1;
      end
      ST_TX: begin
        if (colHit) begin
          if (lateHit) begin
            stateNxt    = ST_IDLE;
            stb.finish  = 1'b1;
            stb.finLate = 1'b1;
          end else begin
            stateNxt    = ST_JAM;
            stb.incColl = 1'b1;
            stb.loadJam = 1'b1;
          end
        end else if (lastNib) begin
          if (hbOn) begin
            stateNxt   = ST_HBWAIT;
            stb.loadHb = 1'b1;
          end else begin
            stateNxt   = ST_IDLE;
            stb.finish = 1'b1;
          end
        end else begin
          stb.incNib = 1'b1;
        end
      end
      ST_JAM: begin
        if (!tmrZero) begin
          stb.decTmr = 1'b1;
        end else if (collCnt == COLL_W'(MAX_ATTEMPTS)) begin
          stateNxt     = ST_IDLE;
          stb.finish   = 1'b1;
          stb.finLimit = 1'b1;
        end else begin
          stateNxt        = ST_BACKOFF;
          stb.loadBackoff = 1'b1;
        end
      end
      ST_BACKOFF: if (!frozen) begin
        if (tmrZero) begin
          stateNxt   = ST_TX;
          stb.clrNib = 1'b1;
        end else begin
          stb.decTmr = 1'b1;
        end
      end
      ST_HBWAIT: begin
        if (phyCol) begin
          stateNxt   = ST_IDLE;
          stb.finish = 1'b1;
        end else if (tmrZero) begin
          stateNxt      = ST_IDLE;
          stb.finish    = 1'b1;
          stb.finHbMiss = 1'b1;
        end else begin
          stb.decTmr = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  assign txEn      = (state == ST_TX) | (state == ST_JAM);
  assign jamEn     = (state == ST_JAM);
  assign inBackoff = (state == ST_BACKOFF);

endmodule

// File: rtl/coll_supervisor.sv
module coll_supervisor
  import cs_pkg::*;
#(
  parameter int NIB_W            = 12,
  parameter int SLOT_CLKS        = 128,
  parameter int BO_CAP           = 10,
  parameter int MAX_ATTEMPTS     = 16,
  parameter int JAM_CLKS         = 8,
  parameter int HB_CLKS          = 40,
  parameter int LATE_LONG_BYTES  = 64,
  parameter int LATE_SHORT_BYTES = 56,
  localparam int RC_W   = $clog2(MAX_ATTEMPTS),
  localparam int COLL_W = $clog2(MAX_ATTEMPTS + 1),
  localparam int TMR_W  = $clog2(((1 << BO_CAP) - 1) * SLOT_CLKS + HB_CLKS + JAM_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgHeartbeat,
  input  logic             cfgForceColl,
  input  logic             cfgStopBackoff,
  input  logic             cfgLocalProtect,
  input  logic             cfgLateSel,
  input  logic             cfgFullDuplex,
  input  logic             txReq,
  input  logic [NIB_W-1:0] frameNibbles,
  input  logic             phyCol,
  input  logic             phyCrs,
  input  logic             rxDvIn,
  output logic             txEn,
  output logic             jamEn,
  output logic             rxDvOut,
  output logic             doneStb,
  output logic             stHbMissing,
  output logic             stLate,
  output logic             stRetryLimit,
  output logic [RC_W-1:0]  stRetryCnt
);

  csStrobe_t         stb;
  logic [NIB_W-1:0]  nibCnt;
  logic [COLL_W-1:0] collCnt;
  logic              tmrZero;
  logic              inBackoff;

  cs_ctrl #(
    .NIB_W(NIB_W), .MAX_ATTEMPTS(MAX_ATTEMPTS), .COLL_W(COLL_W),
    .LATE_LONG_BYTES(LATE_LONG_BYTES), .LATE_SHORT_BYTES(LATE_SHORT_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgHeartbeat(cfgHeartbeat), .cfgForceColl(cfgForceColl),
    .cfgStopBackoff(cfgStopBackoff), .cfgLateSel(cfgLateSel),
    .cfgFullDuplex(cfgFullDuplex), .txReq(txReq), .frameNibbles(frameNibbles),
    .phyCol(phyCol), .phyCrs(phyCrs), .nibCnt(nibCnt), .collCnt(collCnt),
    .tmrZero(tmrZero), .stb(stb), .txEn(txEn), .jamEn(jamEn), .inBackoff(inBackoff)
  );

  cs_datapath #(
    .NIB_W(NIB_W), .SLOT_CLKS(SLOT_CLKS), .BO_CAP(BO_CAP),
    .MAX_ATTEMPTS(MAX_ATTEMPTS), .JAM_CLKS(JAM_CLKS), .HB_CLKS(HB_CLKS),
    .COLL_W(COLL_W), .RC_W(RC_W), .TMR_W(TMR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .nibCnt(nibCnt), .collCnt(collCnt),
    .tmrZero(tmrZero), .doneStb(doneStb), .stHbMissing(stHbMissing),
    .stLate(stLate), .stRetryLimit(stRetryLimit), .stRetryCnt(stRetryCnt)
  );

  // receive path blocked during transmit unless local protect is set
  assign rxDvOut = rxDvIn & (cfgLocalProtect | ~txEn);

endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int RC_W         = 4,
  parameter int MAX_ATTEMPTS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfgHeartbeat,
  input logic            cfgStopBackoff,
  input logic            cfgLocalProtect,
  input logic            cfgFullDuplex,
  input logic            phyCrs,
  input logic            txEn,
  input logic            jamEn,
  input logic            rxDvOut,
  input logic            doneStb,
  input logic            stHbMissing,
  input logic            stLate,
  input logic            stRetryLimit,
  input logic [RC_W-1:0] stRetryCnt,
  input logic            inBackoff
);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneStb |=> !doneStb);

  // R9
  rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txEn && !cfgLocalProtect) |-> !rxDvOut);

  // R3
  jam_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jamEn |-> txEn);

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inBackoff && cfgStopBackoff && phyCrs) |=> !txEn);

  // R6
  limit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneStb && stRetryLimit) |-> (stRetryCnt == RC_W'(MAX_ATTEMPTS - 1)));

  // R10
  fd_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneStb && cfgFullDuplex) |-> (!stLate && !stRetryLimit && !stHbMissing));

  // R8
  hb_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneStb && stHbMissing) |-> cfgHeartbeat);

endmodule

bind coll_supervisor cs_checker #(.RC_W(RC_W), .MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (.*);

// File: tb/tb_coll_supervisor.sv
module tb_coll_supervisor;

  localparam int SLOT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgHeartbeat = 0, cfgForceColl = 0, cfgStopBackoff = 0;
  logic cfgLocalProtect = 0, cfgLateSel = 0, cfgFullDuplex = 0;
  logic txReq = 0, phyCol = 0, phyCrs = 0, rxDvIn = 0;
  logic [11:0] frameNibbles = 12'd20;
  logic txEn, jamEn, rxDvOut, doneStb, stHbMissing, stLate, stRetryLimit;
  logic [3:0] stRetryCnt;

  coll_supervisor #(.SLOT_CLKS(SLOT)) dut (.*);

  always #10 clk = ~clk;

  int nChecks = 0, nErr = 0;
  string curReq = "R12";
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  endtask

  // behavioural reference: 0 idle, 1 send, 2 jam, 3 backoff, 4 heartbeat wait
  int mState = 0, mNib = 0, mColl = 0, mJam = 0, mHb = 0, mActive = 0;
  bit mFrozenLast = 0, mDone = 0;
  int eLate = 0, eLimit = 0, eHb = 0, eRc = 0;

  function automatic void fin(int late, int lim, int hb);
    mState = 0; mDone = 1;
    eLate = late; eLimit = lim; eHb = hb;
    eRc = lim ? 15 : mColl;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mState = 0; mDone = 0; mColl = 0;
      eLate = 0; eLimit = 0; eHb = 0; eRc = 0;
    end else begin
      mDone = 0;
      case (mState)
        0: if (txReq) begin mState = 1; mNib = 0; mColl = 0; end
        1: begin
          if ((phyCol || (cfgForceColl && mNib == 0)) && !cfgFullDuplex) begin
            if (mNib >= (cfgLateSel ? 112 : 128)) fin(1, 0, 0);
            else begin mState = 2; mJam = 0; mColl++; end
          end else if (mNib == int'(frameNibbles) - 1) begin
            if (cfgHeartbeat && !cfgFullDuplex) begin mState = 4; mHb = 0; end
            else fin(0, 0, 0);
          end else mNib++;
        end
        2: begin
          mJam++;
          if (mJam == 8) begin
            if (mColl == 16) fin(0, 1, 0);
            else begin mState = 3; mActive = 0; mFrozenLast = 0; end
          end
        end
        3: if (cfgStopBackoff && phyCrs) mFrozenLast = 1;
           else begin mActive++; mFrozenLast = 0; end
        4: if (phyCol) fin(0, 0, 0);
           else begin mHb++; if (mHb == 40) fin(0, 0, 1); end
        default: mState = 0;
      endcase
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (mState == 3) begin
        int k, maxSlots;
        k = (mColl < 10) ? mColl : 10;
        maxSlots = (1 << k) - 1;
        if (txEn) begin
          chk(((mActive - 1) % SLOT == 0) && ((mActive - 1) / SLOT <= maxSlots),
              "R4", "backoff cycles", mActive, maxSlots * SLOT + 1);
          chk(!mFrozenLast, "R5", "restart while carrier frozen", 1, 0);
          mState = 1; mNib = 0;
        end else if (mActive > maxSlots * SLOT + 1) begin
          chk(0, "R4", "backoff too long", mActive, maxSlots * SLOT + 1);
          mState = 0;
        end
      end
      chk(txEn == (mState == 1 || mState == 2), curReq, "txEn", txEn, (mState == 1 || mState == 2));
      chk(jamEn == (mState == 2), "R3", "jamEn", jamEn, (mState == 2));
      chk(rxDvOut == (rxDvIn && (cfgLocalProtect || !(mState == 1 || mState == 2))),
          "R9", "rxDvOut", rxDvOut, (rxDvIn && (cfgLocalProtect || !(mState == 1 || mState == 2))));
      chk(doneStb == mDone, "R11", "doneStb", doneStb, mDone);
      if (mDone && doneStb) begin
        chk(stLate == eLate[0], curReq, "stLate", stLate, eLate);
        chk(stRetryLimit == eLimit[0], curReq, "stRetryLimit", stRetryLimit, eLimit);
        chk(stHbMissing == eHb[0], curReq, "stHbMissing", stHbMissing, eHb);
        chk(int'(stRetryCnt) == eRc, curReq, "stRetryCnt", stRetryCnt, eRc);
      end
    end
  end

  task automatic startFrame(input int len);
    @(negedge clk);
    frameNibbles = 12'(len);
    txReq = 1;
    do @(negedge clk); while (!txEn);
    txReq = 0;
  endtask

  task automatic waitTxStart();
    while (!(txEn && !jamEn)) @(negedge clk);
  endtask

  task automatic colAfter(input int n);
    repeat (n) @(negedge clk);
    phyCol = 1;
    @(negedge clk);
    phyCol = 0;
  endtask

  task automatic waitDone();
    while (!doneStb) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic waitBackoff();
    while (txEn) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    rxDvIn = 1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(!txEn && !jamEn && !doneStb, "R12", "control outputs in reset", {txEn, jamEn, doneStb}, 0);
    chk(!stLate && !stRetryLimit && !stHbMissing && stRetryCnt == 0, "R12", "status in reset",
        {stLate, stRetryLimit, stHbMissing, stRetryCnt}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // plain frame, heartbeat off, R11 and R8 direct completion
    curReq = "R11";
    startFrame(20); waitDone();
    curReq = "R8";
    startFrame(5); waitDone();

    // R1 boundary 64 bytes
    curReq = "R1";
    cfgLateSel = 0;
    startFrame(200); colAfter(127); waitBackoff(); waitTxStart(); waitDone();
    startFrame(200); colAfter(128); waitDone();

    // R2 boundary 56 bytes
    curReq = "R2";
    cfgLateSel = 1;
    startFrame(200); colAfter(111); waitBackoff(); waitTxStart(); waitDone();
    startFrame(200); colAfter(112); waitDone();
    cfgLateSel = 0;

    // R8 heartbeat in last cycle of window, then missing
    curReq = "R8";
    cfgHeartbeat = 1;
    startFrame(30);
    while (txEn) @(negedge clk);
    colAfter(39); waitDone();
    startFrame(30); waitDone();
    cfgHeartbeat = 0;

    // R9 local protect
    curReq = "R9";
    cfgLocalProtect = 0; startFrame(25); waitDone();
    cfgLocalProtect = 1; startFrame(25); waitDone();

    // R10 full duplex ignores collisions and heartbeat
    curReq = "R10";
    cfgFullDuplex = 1; cfgHeartbeat = 1; cfgForceColl = 1;
    startFrame(150); colAfter(10); colAfter(125); waitDone();
    cfgFullDuplex = 0; cfgHeartbeat = 0; cfgForceColl = 0;

    // R3 and R5: carrier during backoff, freeze on then off
    curReq = "R5";
    cfgStopBackoff = 1;
    startFrame(40); colAfter(10);
    while (jamEn) @(negedge clk);
    phyCrs = 1; repeat (200) @(negedge clk); phyCrs = 0;
    waitTxStart(); waitDone();
    cfgStopBackoff = 0;
    startFrame(40); colAfter(10);
    while (jamEn) @(negedge clk);
    phyCrs = 1; waitTxStart(); phyCrs = 0;
    curReq = "R3";
    waitDone();

    // R6 sixteen real collisions
    curReq = "R6";
    startFrame(40);
    for (int i = 0; i < 16; i++) begin
      waitTxStart(); colAfter(5); waitBackoff();
    end
    waitDone();

    // R7 forced collision self-test
    curReq = "R7";
    cfgForceColl = 1;
    startFrame(30); waitDone();
    cfgForceColl = 0;

    curReq = "R11";
    startFrame(12); waitDone();
    finishRun();
  end

endmodule